// File: doc/BRIEF.md
# Multi-Mode Integer Multiply-Accumulate Unit

This block is a multicycle integer multiplier that keeps a 64-bit accumulator, presented as two 32-bit halves. A single-cycle start request carries an operation code, two 32-bit operands and a signed/unsigned selector. The unit then multiplies either the low halfwords (short modes) or the full words (wide modes). It either overwrites the accumulator with the product or adds the product into it, wrapping modulo 2^64.

Wide products are assembled from 17x17 signed partial products on a pair of multipliers. When the upper half of an operand carries no information, its partial products are skipped. In unsigned mode that means an all-zero upper half. In signed mode it means an upper half that only repeats bit 15. The latency therefore depends on the data. It always stays inside a fixed bound for each mode. A clear input zeroes the accumulator while the unit is idle.

Top module: `mac_unit`

## Requirements
- R1: After reset `busy` and `done` are low and both `acc_hi` and `acc_lo` read zero.
- R2: `op`=0 (short multiply) forms the product of `op_a[15:0]` and `op_b[15:0]`. Both halfwords are sign-extended when `sgn`=1 and zero-extended when `sgn`=0. The low 32 bits of the product go to `acc_lo` and `acc_hi` is left unchanged. Latency is 1.
- R3: `op`=1 (short accumulate) extends the same 16x16 product to 64 bits and adds it to {`acc_hi`,`acc_lo`} modulo 2^64. The product is sign-extended when `sgn`=1 and zero-extended otherwise. Latency is 2.
- R4: `op`=2 (wide multiply) writes the 64-bit product of `op_a` and `op_b` to {`acc_hi`,`acc_lo`}. The operands are two's complement when `sgn`=1 and unsigned when `sgn`=0.
- R5: `op`=3 (wide accumulate) adds the 64-bit product, formed as in R4, to {`acc_hi`,`acc_lo`} modulo 2^64.
- R6: Latency is the number of rising edges from the edge that samples an accepted start to the edge after which `done` is high. A wide mode takes 2 cycles when both operands' upper halves are trivial, 3 when exactly one is, and 4 when neither is. An upper half is trivial when it equals zero (`sgn`=0) or sixteen copies of bit 15 (`sgn`=1). Every mode stays within its bound: short multiply 1 to 2, short accumulate 2 to 3, wide modes 2 to 4.
- R7: `busy` is high from the cycle after an accepted start until `done` rises. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R8: A start while `busy` is high is ignored. Neither the result nor the latency of the running operation changes.
- R9: The accumulator outputs change only in the `done` cycle or after a clear. They stay stable while busy and while idle without start or clear.
- R10: `clr` high while idle and without `start` zeroes both accumulator halves in the next cycle. It is ignored while busy. When `start` and `clr` coincide in an idle cycle, the start wins and the clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request |
| op | input | 2 | Operation code: 0 short mul, 1 short mac, 2 wide mul, 3 wide mac |
| sgn | input | 1 | 1 = two's complement operands, 0 = unsigned |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| clr | input | 1 | Zero the accumulator when idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_hi | output | 32 | Accumulator upper half |
| acc_lo | output | 32 | Accumulator lower half |

## Verification
The hardest situations to reach from the ports are the skip decisions in signed mode. Examples are a word whose upper half is zero but whose bit 15 is set, or an all-ones upper half over a clear bit 15. Uniform random words almost never produce them. The stimulus therefore draws each operand from three classes: full random words, zero-extended halfwords and sign-extended halfwords. Directed cases pin each latency of 2, 3 and 4, together with the extreme products and a carry that wraps through the top of the accumulator. Further directed cases drive a start and a clear in the middle of a busy operation, and a start together with a clear while idle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MAC_S = 2'd1,
    OP_MUL_W = 2'd2,
    OP_MAC_W = 2'd3
  } mac_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_CROSS = 3'd2,
    ST_HIGH  = 3'd3,
    ST_WRITE = 3'd4
  } mac_state_e;
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain[STAGES-1];
endmodule

// File: rtl/mac_split.sv
// Splits a word into a low and a high 17-bit signed part so that
// word = hi * 2^HW + lo. A trivial upper half is folded into lo.
module mac_split #(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic          sgn,
  input  logic          short_mode,
  input  logic [DW-1:0] word,
  output logic [HW:0]   lo_part,
  output logic [HW:0]   hi_part,
  output logic          triv
);
  logic upper_redundant;

  always_comb begin
    if (sgn) upper_redundant = (word[DW-1:HW] == {HW{word[HW-1]}});
    else     upper_redundant = (word[DW-1:HW] == '0);
    triv = short_mode | upper_redundant;
    if (triv) begin
      lo_part = {sgn & word[HW-1], word[HW-1:0]};
      hi_part = '0;
    end else begin
      lo_part = {1'b0, word[HW-1:0]};
      hi_part = {sgn & word[DW-1], word[DW-1:HW]};
    end
  end
endmodule

// File: rtl/mac_pp.sv
module mac_pp #(
  parameter int W = 17
) (
  input  logic signed [W-1:0]   x,
  input  logic signed [W-1:0]   y,
  output logic signed [2*W-1:0] p
);
  assign p = x * y;
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  mac_op_e    op_q,
  input  logic       triv_a,
  input  logic       triv_b,
  output mac_state_e state,
  output logic       accept,
  output logic       fin,
  output logic       busy,
  output logic       done
);
  mac_state_e state_nxt;
  logic       done_q;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);
  assign done   = done_q;

  always_comb begin
    state_nxt = state;
    fin       = 1'b0;
    unique case (state)
      ST_IDLE:  if (accept) state_nxt = ST_LOW;
      ST_LOW: begin
        if (op_q == OP_MUL_S) begin
          state_nxt = ST_IDLE;
          fin       = 1'b1;
        end else if (op_q == OP_MAC_S) begin
          state_nxt = ST_WRITE;
        end else if (!triv_a || !triv_b) begin
          state_nxt = ST_CROSS;
        end else begin
          state_nxt = ST_WRITE;
        end
      end
      ST_CROSS: state_nxt = (!triv_a && !triv_b) ? ST_HIGH : ST_WRITE;
      ST_HIGH:  state_nxt = ST_WRITE;
      ST_WRITE: begin
        state_nxt = ST_IDLE;
        fin       = 1'b1;
      end
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      state  <= state_nxt;
      done_q <= fin;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          sgn,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          clr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo
);
  localparam int HW = DW / 2;
  localparam int PP = HW + 1;
  localparam int PW = 2 * PP;
  localparam int AW = 2 * DW;
  localparam int NMUL = 2;

  logic          rst_q_n;
  mac_state_e    state;
  logic          accept, fin;
  logic [DW-1:0] a_q, b_q;
  logic          sgn_q;
  mac_op_e       op_q;
  logic          short_mode;
  logic [HW:0]   a_lo, a_hi, b_lo, b_hi;
  logic          triv_a, triv_b;
  logic [PP-1:0] mx [NMUL];
  logic [PP-1:0] my [NMUL];
  logic [PW-1:0] pr [NMUL];
  logic [AW-1:0] pe [NMUL];
  logic [AW-1:0] psum, psum_nxt, acc_nxt, acc_cur;
  logic          psum_en, clr_do, acc_en;

  mac_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  mac_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_q_n), .start(start), .op_q(op_q),
    .triv_a(triv_a), .triv_b(triv_b), .state(state), .accept(accept),
    .fin(fin), .busy(busy), .done(done)
  );

  // operand capture, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
      op_q  <= OP_MUL_S;
    end else if (accept) begin
      a_q   <= op_a;
      b_q   <= op_b;
      sgn_q <= sgn;
      op_q  <= mac_op_e'(op);
    end
  end

  assign short_mode = !op_q[1];

  mac_split #(.DW(DW)) i_split_a (
    .sgn(sgn_q), .short_mode(short_mode), .word(a_q),
    .lo_part(a_lo), .hi_part(a_hi), .triv(triv_a)
  );

  mac_split #(.DW(DW)) i_split_b (
    .sgn(sgn_q), .short_mode(short_mode), .word(b_q),
    .lo_part(b_lo), .hi_part(b_hi), .triv(triv_b)
  );

  // partial-product operand selection per step
  always_comb begin
    mx[0] = a_lo;  my[0] = b_lo;
    mx[1] = '0;    my[1] = '0;
    if (state == ST_CROSS) begin
      mx[0] = a_lo;  my[0] = b_hi;
      mx[1] = a_hi;  my[1] = b_lo;
    end else if (state == ST_HIGH) begin
      mx[0] = a_hi;  my[0] = b_hi;
    end
  end

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    mac_pp #(.W(PP)) i_pp (.x(mx[g]), .y(my[g]), .p(pr[g]));
    assign pe[g] = {{(AW-PW){pr[g][PW-1]}}, pr[g]};
  end

  always_comb begin
    psum_en  = 1'b0;
    psum_nxt = psum;
    unique case (state)
      ST_LOW:   begin psum_en = 1'b1; psum_nxt = pe[0]; end
      ST_CROSS: begin psum_en = 1'b1; psum_nxt = psum + ((pe[0] + pe[1]) << HW); end
      ST_HIGH:  begin psum_en = 1'b1; psum_nxt = psum + (pe[0] << DW); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     psum <= '0;
    else if (psum_en) psum <= psum_nxt;
  end

  // accumulator update: result write has priority, clear only when idle
  assign acc_cur = {acc_hi, acc_lo};
  assign clr_do  = clr && !start && (state == ST_IDLE);
  assign acc_en  = fin || clr_do;

  always_comb begin
    acc_nxt = '0;
    if (fin) begin
      if (op_q == OP_MUL_S) acc_nxt = {acc_hi, pr[0][DW-1:0]};
      else if (op_q[0])     acc_nxt = acc_cur + psum;
      else                  acc_nxt = psum;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
    end else if (acc_en) begin
      acc_hi <= acc_nxt[AW-1:DW];
      acc_lo <= acc_nxt[DW-1:0];
    end
  end
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    op,
  input logic          clr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] acc_hi,
  input logic [DW-1:0] acc_lo
);
  logic [2:0] cnt;
  logic [1:0] op_c;
  logic [2:0] lat_lo, lat_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= 3'd0;
      op_c <= 2'd0;
    end else if (start && !busy) begin
      cnt  <= 3'd0;
      op_c <= op;
    end else if (busy && cnt != 3'd7) begin
      cnt  <= cnt + 3'd1;
    end
  end

  always_comb begin
    case (op_c)
      2'd0:    begin lat_lo = 3'd1; lat_hi = 3'd2; end
      2'd1:    begin lat_lo = 3'd2; lat_hi = 3'd3; end
      default: begin lat_lo = 3'd2; lat_hi = 3'd4; end
    endcase
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_latency_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt >= lat_lo && cnt <= lat_hi));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable({acc_hi, acc_lo})));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !clr) |=> $stable({acc_hi, acc_lo}));

  assert_short_keeps_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_c == 2'd0) |=> $stable(acc_hi));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !start && !busy) |=> (acc_hi == '0 && acc_lo == '0));

  assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind mac_unit mac_unit_chk #(.DW(DW)) i_mac_unit_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .clr(clr),
  .busy(busy), .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n, start, sgn, clr;
  logic [1:0]  op;
  logic [31:0] op_a, op_b;
  logic        busy, done;
  logic [31:0] acc_hi, acc_lo;
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [63:0] exp_acc;

  always #2.5 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sgn(sgn),
    .op_a(op_a), .op_b(op_b), .clr(clr), .busy(busy), .done(done),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [1:0] o, input logic [31:0] a,
                                           input logic [31:0] b, input logic s);
    logic [63:0] x, y;
    if (!o[1]) begin
      x = s ? {{48{a[15]}}, a[15:0]} : {48'd0, a[15:0]};
      y = s ? {{48{b[15]}}, b[15:0]} : {48'd0, b[15:0]};
    end else begin
      x = s ? {{32{a[31]}}, a} : {32'd0, a};
      y = s ? {{32{b[31]}}, b} : {32'd0, b};
    end
    return x * y;
  endfunction

  function automatic int ref_lat(input logic [1:0] o, input logic [31:0] a,
                                 input logic [31:0] b, input logic s);
    bit ta, tb;
    if (o == 2'd0) return 1;
    if (o == 2'd1) return 2;
    ta = s ? (a[31:16] == {16{a[15]}}) : (a[31:16] == 16'd0);
    tb = s ? (b[31:16] == {16{b[15]}}) : (b[31:16] == 16'd0);
    return 2 + (ta ? 0 : 1) + (tb ? 0 : 1);
  endfunction

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // mid_start: a start with other operands while busy (R8)
  // mid_clr: clear held high while busy (R10), clr_now: clear together with start
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic s, input bit mid_start, input bit mid_clr, input bit clr_now);
    logic [63:0] p, old, nxt;
    int lat, exp_lat;
    p   = ref_prod(o, a, b, s);
    old = exp_acc;
    case (o)
      2'd0: nxt = {old[63:32], p[31:0]};
      2'd2: nxt = p;
      default: nxt = old + p;
    endcase
    exp_lat = ref_lat(o, a, b, s);
    @(negedge clk);
    op = o; op_a = a; op_b = b; sgn = s; start = 1'b1; clr = clr_now;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    lat = 0;
    while (!done && lat < 12) begin
      check("R9 hold while busy", {acc_hi, acc_lo}, old);
      start = mid_start && (lat == 0);
      clr   = mid_clr;
      if (mid_start) begin op_a = ~a; op_b = ~b; op = ~o; end
      @(negedge clk);
      lat++;
    end
    start = 1'b0; clr = 1'b0; op_a = a; op_b = b; op = o;
    check(o[1] ? "R6 latency" : {op_tag(o), " latency"}, 64'(lat), 64'(exp_lat));
    check({op_tag(o), mid_start ? " R8" : "", mid_clr ? " R10 busy clr" : "",
           clr_now ? " R10 start wins" : ""}, {acc_hi, acc_lo}, nxt);
    exp_acc = nxt;
    @(negedge clk);
    check("R7 done pulse", {63'd0, done}, 64'd0);
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    w = $urandom;
    case ($urandom % 3)
      0: return w;
      1: return {16'd0, w[15:0]};
      default: return {{16{w[15]}}, w[15:0]};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R7 actual=no finish expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; start = 1'b0; clr = 1'b0; op = 2'd0; sgn = 1'b0;
    op_a = '0; op_b = '0; exp_acc = '0;
    repeat (3) @(negedge clk);
    check("R1 reset busy/done", {62'd0, busy, done}, 64'd0);
    check("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    run_op(2'd2, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 0, 0, 0); // wide, lat 4
    run_op(2'd0, 32'h0000_FFFF, 32'h7777_FFFF, 1'b1, 0, 0, 0); // -1*-1, hi kept
    run_op(2'd2, 32'd5, 32'd7, 1'b0, 0, 0, 0);                 // lat 2
    run_op(2'd2, 32'h0001_0000, 32'd3, 1'b0, 0, 0, 0);         // lat 3
    run_op(2'd2, 32'hFFFF_FFFD, 32'hFFFF_8000, 1'b1, 0, 0, 0); // signed trivial, lat 2
    run_op(2'd2, 32'hFFFF_FFFD, 32'h0000_8000, 1'b1, 0, 0, 0); // bit15 set, lat 3
    run_op(2'd2, 32'h8000_0000, 32'h8000_0000, 1'b1, 0, 0, 0); // 2^62
    run_op(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, 0, 0); // max unsigned
    run_op(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, 0, 0); // wraps
    run_op(2'd1, 32'h0000_8000, 32'h0000_8000, 1'b1, 0, 0, 0); // short mac signed
    run_op(2'd1, 32'hABCD_FFFF, 32'h1234_FFFF, 1'b0, 0, 0, 0); // short mac unsigned
    run_op(2'd3, 32'h7FFF_FFFF, 32'h8000_0001, 1'b1, 1, 0, 0); // restart ignored
    run_op(2'd1, 32'h0000_0003, 32'h0000_0005, 1'b0, 0, 1, 0); // clear while busy
    run_op(2'd3, 32'h0002_0000, 32'h0003_0000, 1'b0, 0, 0, 1); // start beats clear

    // idle hold and idle clear
    repeat (3) @(negedge clk);
    check("R9 idle hold", {acc_hi, acc_lo}, exp_acc);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_acc = '0;
    check("R10 idle clear", {acc_hi, acc_lo}, 64'd0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      run_op(2'($urandom % 4), rand_word(), rand_word(), 1'($urandom % 2),
             ($urandom % 8) == 0, ($urandom % 10) == 0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule